// File: doc/BRIEF.md
# Command Byte Configuration Decoder

This block interprets byte transactions delivered by a serial slave front end and keeps the settings of a keypad controller. Each transaction begins with a start pulse. The first byte written after the start selects a command. Any further written bytes are parameters. Bytes read back are response bytes. Parameters and response bytes are both numbered from zero. A command stays selected across later start pulses, so a host can write a command code and then open a read transaction to collect its answer.

The block stores the following settings:
- the configuration byte
- the active time
- the debounce time
- the keypad dimensions
- the clock setup byte
- three 16-bit GPIO words: pull select, direction and state mask

Each write command checks its own parameter. An illegal value sets a sticky error bit. Any error also raises a status bit, and that status bit drives the active-low interrupt. When a write command has taken its last parameter, it disarms itself. Any extra byte written after that point is reported as a parameter error.

Two groups of commands are served by neighbouring blocks: the key queue reads and the PWM commands. The decoder accepts them without raising an error. For those reads it returns zero.

Top module: `cmd_reg_decoder`

## Requirements
- R1: A pulse on `xfer_start_i` clears the byte index. The next written byte becomes the selected command and re-arms it. Each later written byte is parameter number (index − 1). Read bytes take response number equal to the index. The index saturates at its maximum and never wraps.
- R2: After `rst`, the outputs are:
  - configuration 0x80, active time 125, debounce 3, keypad size 0x33, clock setup 0x08
  - all three GPIO words 0, error byte 0
  - status 0x10 (bit 4 = not yet configured), so `irq_n_o` is low.
- R3: The GPIO commands are 0x84 (pull), 0x85 (direction) and 0x86 (mask).
  - Parameter 0 loads the low byte and clears the high byte.
  - Parameter 1 ORs its value into the high byte and then disarms the command.
- R4: Command 0x83 with parameter 0xAA restores the R2 values of the five setting bytes and sets the status to 0x10. It leaves the GPIO words and the error byte unchanged. Any other parameter value sets error bit 0 (bad parameter). Either way the command is disarmed.
- R5: Command 0x8F stores the debounce byte, and a value of zero also sets error bit 0. Command 0x8B stores the active time without any check. Both commands are disarmed afterwards.
- R6: Command 0x90 always stores the keypad byte. It sets error bit 0 when the low nibble is outside 3..12 or the high nibble is outside 3..8.
- R7: Command 0x93 always stores the clock byte. It sets error bit 0 when the two low bits are 01 or 10.
- R8: Command 0x81 stores the configuration byte, clears the whole status byte and disarms the command. In the cycle after the write, `queue_flush_o` pulses high for exactly one cycle.
- R9: A parameter write to a disarmed command sets error bit 0. A read of a disarmed command returns 0 and sets error bit 1 (unknown command).
- R10: The following set error bit 1:
  - a parameter write to any code that is not a write command
  - a read of any code that is not a read command

  The codes 0x89, 0x8A, 0x95, 0x96 and 0x97 belong to other blocks. They raise no error and read as 0.
- R11: Every error sets status bit 3, which drives `irq_n_o` low. The error bits stay set until `rst`.
- R12: Read responses are:
  - 0x80: the word 0x0400
  - 0x82: the status byte
  - 0x87: the direction word
  - 0x88: the mask word
  - 0x8C: the error byte
  - 0x8E: zero
  - 0x91: the keypad byte
  - 0x92: the configuration byte ANDed with 0x0F
  - 0x94: the clock byte ANDed with 0xFC, then ORed with 0x02

  Response k returns bits 8k+7..8k of the value. Bytes beyond bit 15 read as 0, and so do the upper bytes of 8-bit values.
- R13: Reading 0x82 clears the status byte, unless status bit 4 is set; in that case the status is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start_i | input | 1 | Start condition of a transaction |
| wr_stb_i | input | 1 | Written byte valid |
| wr_byte_i | input | 8 | Written byte |
| rd_stb_i | input | 1 | Response byte consumed |
| rd_byte_o | output | 8 | Response byte at the current index |
| irq_n_o | output | 1 | Active-low interrupt, low while the status is nonzero |
| queue_flush_o | output | 1 | One-cycle request to empty the key queue |
| cfg_o | output | 8 | Configuration byte |
| act_time_o | output | 8 | Active time |
| dbnc_o | output | 8 | Debounce time |
| ksize_o | output | 8 | Keypad dimensions (high nibble columns, low nibble rows) |
| clk_cfg_o | output | 8 | Clock setup byte |
| gpio_pull_o | output | 16 | GPIO pull select |
| gpio_dir_o | output | 16 | GPIO direction |
| gpio_mask_o | output | 16 | GPIO state mask |
| err_o | output | 8 | Sticky error byte |

## Verification
The bench builds the decoder with its default parameters: a 3-bit byte index and keypad limits of 3..12 rows and 3..8 columns.

With these values the bench can sweep the full 256-value parameter space of the debounce, keypad-size and clock commands. Every legality boundary is therefore hit on both sides, and the masked clock readback is checked for every stored value.

A 3-bit index also lets the bench read past the 16-bit responses into the zero region, and write past a disarmed command, within a few bytes.

// File: rtl/cfgdec_pkg.sv
package cfgdec_pkg;

    localparam int BYTE_W = 8;
    localparam int GPIO_W = 16;

    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [GPIO_W-1:0] gword_t;

    typedef enum logic [7:0] {
        OP_ID       = 8'h80,
        OP_CFG_WR   = 8'h81,
        OP_STAT_RD  = 8'h82,
        OP_SOFT_RST = 8'h83,
        OP_PULL_WR  = 8'h84,
        OP_DIR_WR   = 8'h85,
        OP_MASK_WR  = 8'h86,
        OP_DIR_RD   = 8'h87,
        OP_MASK_RD  = 8'h88,
        OP_Q_POP    = 8'h89,
        OP_Q_PEEK   = 8'h8A,
        OP_ACT_WR   = 8'h8B,
        OP_ERR_RD   = 8'h8C,
        OP_ROT_RD   = 8'h8E,
        OP_DBNC_WR  = 8'h8F,
        OP_KSZ_WR   = 8'h90,
        OP_KSZ_RD   = 8'h91,
        OP_CFG_RD   = 8'h92,
        OP_CLK_WR   = 8'h93,
        OP_CLK_RD   = 8'h94,
        OP_PWM_LOAD = 8'h95,
        OP_PWM_GO   = 8'h96,
        OP_PWM_HALT = 8'h97
    } op_e;

    typedef struct packed {
        byte_t cfg;
        byte_t act;
        byte_t dbnc;
        byte_t ksize;
        byte_t clk;
    } setup_t;

    localparam setup_t SETUP_DFLT = '{cfg: 8'h80, act: 8'd125, dbnc: 8'd3,
                                      ksize: 8'h33, clk: 8'h08};

    localparam int    EB_BADPAR = 0;
    localparam int    EB_UNKCMD = 1;
    localparam int    SB_ERROR  = 3;
    localparam int    SB_NOINIT = 4;
    localparam byte_t ST_FRESH  = byte_t'(1 << SB_NOINIT);
    localparam byte_t RST_KEY   = 8'hAA;
    localparam gword_t ID_WORD  = 16'h0400;

    function automatic logic ksize_bad(input byte_t v, input int rmin, input int rmax,
                                       input int cmin, input int cmax);
        int rows;
        int cols;
        rows = int'(v[3:0]);
        cols = int'(v[7:4]);
        return (rows < rmin) || (rows > rmax) || (cols < cmin) || (cols > cmax);
    endfunction

    function automatic logic clk_bad(input byte_t v);
        return (v[1:0] == 2'b01) || (v[1:0] == 2'b10);
    endfunction

    function automatic logic is_foreign(input byte_t c);
        case (c)
            OP_Q_POP, OP_Q_PEEK, OP_PWM_LOAD, OP_PWM_GO, OP_PWM_HALT: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_rd_cmd(input byte_t c);
        case (c)
            OP_ID, OP_STAT_RD, OP_DIR_RD, OP_MASK_RD, OP_ERR_RD, OP_ROT_RD,
            OP_KSZ_RD, OP_CFG_RD, OP_CLK_RD: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic is_single(input byte_t c);
        case (c)
            OP_CFG_WR, OP_SOFT_RST, OP_ACT_WR, OP_DBNC_WR, OP_KSZ_WR, OP_CLK_WR: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/cfgdec_seq.sv
module cfgdec_seq
    import cfgdec_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_i,
    input  logic             wr_i,
    input  logic             rd_i,
    input  byte_t            byte_i,
    input  logic             kill_i,
    output byte_t            cmd_o,
    output logic             cmd_ok_o,
    output logic [CNT_W-1:0] idx_o
);
    localparam logic [CNT_W-1:0] IDX_MAX = '1;

    byte_t            cmd_q;
    logic             ok_q;
    logic [CNT_W-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
            ok_q  <= 1'b0;
            idx_q <= '0;
        end else begin
            if (start_i) begin
                idx_q <= '0;
            end else if ((wr_i || rd_i) && idx_q != IDX_MAX) begin
                idx_q <= idx_q + 1'b1;
            end
            if (wr_i && !start_i && idx_q == '0) begin
                cmd_q <= byte_i;
                ok_q  <= 1'b1;
            end else if (kill_i) begin
                ok_q  <= 1'b0;
            end
        end
    end

    assign cmd_o    = cmd_q;
    assign cmd_ok_o = ok_q;
    assign idx_o    = idx_q;

    AST_START_CLEARS_IDX: assert property (@(posedge clk) disable iff (rst)
        start_i |=> idx_q == '0); // R1
    AST_CMD_LATCH: assert property (@(posedge clk) disable iff (rst)
        (wr_i && !start_i && idx_q == '0) |=> (ok_q && cmd_q == $past(byte_i))); // R1
    AST_IDX_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!start_i && idx_q == IDX_MAX) |=> idx_q == IDX_MAX); // R1

endmodule

// File: rtl/cfgdec_regs.sv
module cfgdec_regs
    import cfgdec_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int KP_ROW_MIN = 3,
    parameter int KP_ROW_MAX = 12,
    parameter int KP_COL_MIN = 3,
    parameter int KP_COL_MAX = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_i,
    input  logic             rd_i,
    input  byte_t            byte_i,
    input  byte_t            cmd_i,
    input  logic             cmd_ok_i,
    input  logic [CNT_W-1:0] idx_i,
    output setup_t           setup_o,
    output gword_t           pull_o,
    output gword_t           dir_o,
    output gword_t           mask_o,
    output byte_t            err_o,
    output byte_t            status_o,
    output logic             flush_o,
    output logic             kill_o
);
    localparam logic [CNT_W-1:0] IDX_P0 = CNT_W'(1);

    setup_t setup_q, setup_n;
    gword_t pull_q, pull_n, dir_q, dir_n, mask_q, mask_n;
    byte_t  err_q, err_n, st_q, st_n, raise;
    logic   flush_q, flush_n, kill;

    function automatic gword_t gmerge(input gword_t cur, input byte_t v, input logic lo);
        return lo ? {{(GPIO_W-BYTE_W){1'b0}}, v} : (cur | {v, {(GPIO_W-BYTE_W){1'b0}}});
    endfunction

    always_comb begin
        setup_n = setup_q;
        pull_n  = pull_q;
        dir_n   = dir_q;
        mask_n  = mask_q;
        err_n   = err_q;
        st_n    = st_q;
        flush_n = 1'b0;
        kill    = 1'b0;
        raise   = '0;
        if (wr_i && idx_i != '0) begin
            if (!cmd_ok_i) begin
                raise[EB_BADPAR] = 1'b1;
            end else begin
                case (cmd_i)
                    OP_CFG_WR: begin
                        setup_n.cfg = byte_i;
                        st_n        = '0;
                        flush_n     = 1'b1;
                        kill        = 1'b1;
                    end
                    OP_SOFT_RST: begin
                        kill = 1'b1;
                        if (byte_i == RST_KEY) begin
                            setup_n = SETUP_DFLT;
                            st_n    = ST_FRESH;
                        end else begin
                            raise[EB_BADPAR] = 1'b1;
                        end
                    end
                    OP_PULL_WR: begin
                        pull_n = gmerge(pull_q, byte_i, idx_i == IDX_P0);
                        kill   = (idx_i != IDX_P0);
                    end
                    OP_DIR_WR: begin
                        dir_n = gmerge(dir_q, byte_i, idx_i == IDX_P0);
                        kill  = (idx_i != IDX_P0);
                    end
                    OP_MASK_WR: begin
                        mask_n = gmerge(mask_q, byte_i, idx_i == IDX_P0);
                        kill   = (idx_i != IDX_P0);
                    end
                    OP_ACT_WR: begin
                        setup_n.act = byte_i;
                        kill        = 1'b1;
                    end
                    OP_DBNC_WR: begin
                        setup_n.dbnc     = byte_i;
                        kill             = 1'b1;
                        raise[EB_BADPAR] = (byte_i == '0);
                    end
                    OP_KSZ_WR: begin
                        setup_n.ksize    = byte_i;
                        kill             = 1'b1;
                        raise[EB_BADPAR] = ksize_bad(byte_i, KP_ROW_MIN, KP_ROW_MAX,
                                                     KP_COL_MIN, KP_COL_MAX);
                    end
                    OP_CLK_WR: begin
                        setup_n.clk      = byte_i;
                        kill             = 1'b1;
                        raise[EB_BADPAR] = clk_bad(byte_i);
                    end
                    default: raise[EB_UNKCMD] = !is_foreign(cmd_i);
                endcase
            end
        end else if (rd_i) begin
            if (!cmd_ok_i) begin
                raise[EB_UNKCMD] = 1'b1;
            end else if (cmd_i == OP_STAT_RD) begin
                if (!st_q[SB_NOINIT]) st_n = '0;
            end else if (!is_rd_cmd(cmd_i) && !is_foreign(cmd_i)) begin
                raise[EB_UNKCMD] = 1'b1;
            end
        end
        if (raise != '0) begin
            err_n          = err_n | raise;
            st_n[SB_ERROR] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            setup_q <= SETUP_DFLT;
            pull_q  <= '0;
            dir_q   <= '0;
            mask_q  <= '0;
            err_q   <= '0;
            st_q    <= ST_FRESH;
            flush_q <= 1'b0;
        end else begin
            setup_q <= setup_n;
            pull_q  <= pull_n;
            dir_q   <= dir_n;
            mask_q  <= mask_n;
            err_q   <= err_n;
            st_q    <= st_n;
            flush_q <= flush_n;
        end
    end

    assign setup_o  = setup_q;
    assign pull_o   = pull_q;
    assign dir_o    = dir_q;
    assign mask_o   = mask_q;
    assign err_o    = err_q;
    assign status_o = st_q;
    assign flush_o  = flush_q;
    assign kill_o   = kill;

    AST_DISARM_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
        (wr_i && idx_i != '0 && cmd_ok_i && is_single(cmd_i)) |=> !cmd_ok_i); // R9
    AST_DEAD_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        (wr_i && idx_i != '0 && !cmd_ok_i) |=> (err_q[EB_BADPAR] && st_q[SB_ERROR])); // R9
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((err_q & $past(err_q)) == $past(err_q))); // R11
    AST_SOFT_RST_DFLT: assert property (@(posedge clk) disable iff (rst)
        (wr_i && idx_i != '0 && cmd_ok_i && cmd_i == OP_SOFT_RST && byte_i == RST_KEY)
        |=> (setup_q == SETUP_DFLT && st_q == ST_FRESH)); // R4
    AST_FLUSH_SINGLE: assert property (@(posedge clk) disable iff (rst)
        flush_q |=> !flush_q); // R8

endmodule

// File: rtl/cfgdec_rdmux.sv
module cfgdec_rdmux
    import cfgdec_pkg::*;
#(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_t            cmd_i,
    input  logic             cmd_ok_i,
    input  logic [CNT_W-1:0] idx_i,
    input  byte_t            cfg_i,
    input  byte_t            ksize_i,
    input  byte_t            clk_cfg_i,
    input  gword_t           dir_i,
    input  gword_t           mask_i,
    input  byte_t            err_i,
    input  byte_t            status_i,
    output byte_t            rd_o
);
    localparam int NBYTES = GPIO_W / BYTE_W;

    gword_t word;
    byte_t  pick;

    always_comb begin
        case (cmd_i)
            OP_ID:      word = ID_WORD;
            OP_STAT_RD: word = gword_t'(status_i);
            OP_DIR_RD:  word = dir_i;
            OP_MASK_RD: word = mask_i;
            OP_ERR_RD:  word = gword_t'(err_i);
            OP_KSZ_RD:  word = gword_t'(ksize_i);
            OP_CFG_RD:  word = gword_t'(cfg_i & 8'h0F);
            OP_CLK_RD:  word = gword_t'((clk_cfg_i & 8'hFC) | 8'h02);
            default:    word = '0;
        endcase
    end

    always_comb begin
        pick = '0;
        for (int k = 0; k < NBYTES; k++) begin
            if (int'(idx_i) == k) pick = word[k*BYTE_W +: BYTE_W];
        end
    end

    assign rd_o = cmd_ok_i ? pick : '0;

    AST_RD_PAST_WORD_ZERO: assert property (@(posedge clk) disable iff (rst)
        (int'(idx_i) >= NBYTES) |-> rd_o == '0); // R12
    AST_RD_DISARMED_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cmd_ok_i |-> rd_o == '0); // R9

endmodule

// File: rtl/cmd_reg_decoder.sv
module cmd_reg_decoder
    import cfgdec_pkg::*;
#(
    parameter int CNT_W      = 3,
    parameter int KP_ROW_MIN = 3,
    parameter int KP_ROW_MAX = 12,
    parameter int KP_COL_MIN = 3,
    parameter int KP_COL_MAX = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        xfer_start_i,
    input  logic        wr_stb_i,
    input  logic [7:0]  wr_byte_i,
    input  logic        rd_stb_i,
    output logic [7:0]  rd_byte_o,
    output logic        irq_n_o,
    output logic        queue_flush_o,
    output logic [7:0]  cfg_o,
    output logic [7:0]  act_time_o,
    output logic [7:0]  dbnc_o,
    output logic [7:0]  ksize_o,
    output logic [7:0]  clk_cfg_o,
    output logic [15:0] gpio_pull_o,
    output logic [15:0] gpio_dir_o,
    output logic [15:0] gpio_mask_o,
    output logic [7:0]  err_o
);
    byte_t            cmd;
    logic             cmd_ok, kill;
    logic [CNT_W-1:0] idx;
    setup_t           setup;
    gword_t           pull, dir, mask;
    byte_t            err, status;

    cfgdec_seq #(.CNT_W(CNT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start_i  (xfer_start_i),
        .wr_i     (wr_stb_i),
        .rd_i     (rd_stb_i),
        .byte_i   (wr_byte_i),
        .kill_i   (kill),
        .cmd_o    (cmd),
        .cmd_ok_o (cmd_ok),
        .idx_o    (idx)
    );

    cfgdec_regs #(
        .CNT_W(CNT_W), .KP_ROW_MIN(KP_ROW_MIN), .KP_ROW_MAX(KP_ROW_MAX),
        .KP_COL_MIN(KP_COL_MIN), .KP_COL_MAX(KP_COL_MAX)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_i     (wr_stb_i && !xfer_start_i),
        .rd_i     (rd_stb_i && !xfer_start_i),
        .byte_i   (wr_byte_i),
        .cmd_i    (cmd),
        .cmd_ok_i (cmd_ok),
        .idx_i    (idx),
        .setup_o  (setup),
        .pull_o   (pull),
        .dir_o    (dir),
        .mask_o   (mask),
        .err_o    (err),
        .status_o (status),
        .flush_o  (queue_flush_o),
        .kill_o   (kill)
    );

    cfgdec_rdmux #(.CNT_W(CNT_W)) u_rdmux (
        .clk       (clk),
        .rst       (rst),
        .cmd_i     (cmd),
        .cmd_ok_i  (cmd_ok),
        .idx_i     (idx),
        .cfg_i     (setup.cfg),
        .ksize_i   (setup.ksize),
        .clk_cfg_i (setup.clk),
        .dir_i     (dir),
        .mask_i    (mask),
        .err_i     (err),
        .status_i  (status),
        .rd_o      (rd_byte_o)
    );

    assign irq_n_o     = (status == '0);
    assign cfg_o       = setup.cfg;
    assign act_time_o  = setup.act;
    assign dbnc_o      = setup.dbnc;
    assign ksize_o     = setup.ksize;
    assign clk_cfg_o   = setup.clk;
    assign gpio_pull_o = pull;
    assign gpio_dir_o  = dir;
    assign gpio_mask_o = mask;
    assign err_o       = err;

    AST_ERROR_PULLS_IRQ: assert property (@(posedge clk) disable iff (rst)
        (err != $past(err)) |-> !irq_n_o); // R11

endmodule

// File: tb/sim_cmd_reg_decoder.sv
module sim_cmd_reg_decoder;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        st = 1'b0, wr = 1'b0, rd = 1'b0;
    logic [7:0]  wb = '0;
    logic [7:0]  rb, cfg, act, dbnc, ksz, ckc, err;
    logic        irq_n, flush;
    logic [15:0] pull, dir, mask;
    int          nchk = 0, nfail = 0;

    always #5 clk = ~clk;

    cmd_reg_decoder u0 (
        .clk(clk), .rst(rst), .xfer_start_i(st), .wr_stb_i(wr), .wr_byte_i(wb),
        .rd_stb_i(rd), .rd_byte_o(rb), .irq_n_o(irq_n), .queue_flush_o(flush),
        .cfg_o(cfg), .act_time_o(act), .dbnc_o(dbnc), .ksize_o(ksz), .clk_cfg_o(ckc),
        .gpio_pull_o(pull), .gpio_dir_o(dir), .gpio_mask_o(mask), .err_o(err)
    );

    task automatic chk(input string req, input logic [15:0] actv, input logic [15:0] expv);
        nchk++;
        if (actv !== expv) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, actv, expv, $time);
        end
    endtask

    task automatic do_rst();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic xs();
        st = 1'b1; @(negedge clk); st = 1'b0;
    endtask

    task automatic wbyte(input logic [7:0] v);
        wr = 1'b1; wb = v; @(negedge clk); wr = 1'b0;
    endtask

    task automatic rbyte(input string req, input logic [7:0] expv);
        chk(req, {8'h00, rb}, {8'h00, expv});
        rd = 1'b1; @(negedge clk); rd = 1'b0;
    endtask

    task automatic cmd1(input logic [7:0] c, input logic [7:0] v);
        xs(); wbyte(c); wbyte(v);
    endtask

    task automatic rd_open(input logic [7:0] c);
        xs(); wbyte(c); xs();
    endtask

    function automatic logic ksz_bad_f(input logic [7:0] v);
        return (v[3:0] < 3) || (v[3:0] > 12) || (v[7:4] < 3) || (v[7:4] > 8);
    endfunction

    initial begin
        #2_000_000;
        nfail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        @(negedge clk);
        do_rst();
        // R2 reset values
        chk("R2 cfg", {8'h0, cfg}, 16'h80);
        chk("R2 act", {8'h0, act}, 16'd125);
        chk("R2 dbnc", {8'h0, dbnc}, 16'd3);
        chk("R2 ksize", {8'h0, ksz}, 16'h33);
        chk("R2 clk", {8'h0, ckc}, 16'h08);
        chk("R2 gpio", pull | dir | mask, 16'h0);
        chk("R2 err", {8'h0, err}, 16'h0);
        chk("R2 irq_n", {15'h0, irq_n}, 16'h0);
        // R13 status kept while not configured
        rd_open(8'h82); rbyte("R13 fresh status", 8'h10);
        xs(); rbyte("R13 status kept", 8'h10);
        // R12 / R1 ID read and byte indexing
        rd_open(8'h80);
        rbyte("R12 id b0", 8'h00); rbyte("R12 id b1", 8'h04);
        rbyte("R12 id b2", 8'h00); rbyte("R1 id b3", 8'h00);
        for (int i = 0; i < 8; i++) rbyte("R1 index saturates", 8'h00);
        chk("R1 no error on reads", {8'h0, err}, 16'h0);
        // R8 configuration write
        xs(); wbyte(8'h81); wbyte(8'h5A);
        chk("R8 flush pulse", {15'h0, flush}, 16'h1);
        @(negedge clk);
        chk("R8 flush one cycle", {15'h0, flush}, 16'h0);
        chk("R8 cfg stored", {8'h0, cfg}, 16'h5A);
        chk("R8 irq released", {15'h0, irq_n}, 16'h1);
        rd_open(8'h92); rbyte("R12 cfg low nibble", 8'h0A); rbyte("R12 cfg b1", 8'h00);
        rd_open(8'h82); rbyte("R8 status cleared", 8'h00);
        // R9 extra byte after disarm
        xs(); wbyte(8'h81); wbyte(8'h00); wbyte(8'h11);
        chk("R9 dead write badpar", {8'h0, err}, 16'h01);
        chk("R11 irq low", {15'h0, irq_n}, 16'h0);
        rd_open(8'h82); rbyte("R11 status error bit", 8'h08);
        xs(); rbyte("R13 status cleared by read", 8'h00);
        chk("R13 irq released", {15'h0, irq_n}, 16'h1);
        chk("R11 err sticky", {8'h0, err}, 16'h01);
        rd_open(8'h8C); rbyte("R12 err read", 8'h01);
        // R9 read while disarmed
        do_rst(); cmd1(8'h8B, 8'h40);
        chk("R5 act stored", {8'h0, act}, 16'h40);
        chk("R5 act no check", {8'h0, err}, 16'h00);
        xs(); rbyte("R9 disarmed read zero", 8'h00);
        chk("R9 disarmed read unk", {8'h0, err}, 16'h02);
        // R10 unknown and misdirected commands
        do_rst(); cmd1(8'h8D, 8'h01);
        chk("R10 unknown write", {8'h0, err}, 16'h02);
        do_rst(); cmd1(8'h80, 8'h05);
        chk("R10 write to read cmd", {8'h0, err}, 16'h02);
        do_rst(); rd_open(8'h8B); rbyte("R10 read of write cmd", 8'h00);
        chk("R10 read of write cmd err", {8'h0, err}, 16'h02);
        do_rst(); cmd1(8'h89, 8'h33); cmd1(8'h96, 8'h07);
        rd_open(8'h8A); rbyte("R10 foreign read", 8'h00);
        chk("R10 foreign no error", {8'h0, err}, 16'h00);
        rd_open(8'h8E); rbyte("R12 rotator", 8'h00);
        // R3 GPIO words
        for (int c = 0; c < 3; c++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0]  lo, hi;
                logic [15:0] got;
                lo = 8'(8'h1F * (p + 1) + c);
                hi = 8'(8'hA5 ^ (p * 8'h31) ^ c);
                do_rst();
                xs(); wbyte(8'(8'h84 + c)); wbyte(8'hFF); wbyte(8'hFF);
                xs(); wbyte(8'(8'h84 + c)); wbyte(lo);
                got = (c == 0) ? pull : (c == 1) ? dir : mask;
                chk("R3 low byte clears high", got, {8'h00, lo});
                wbyte(hi);
                got = (c == 0) ? pull : (c == 1) ? dir : mask;
                chk("R3 high byte merged", got, {hi, lo});
                chk("R3 no error", {8'h0, err}, 16'h00);
                wbyte(8'h3C);
                chk("R3 disarmed after high", {8'h0, err}, 16'h01);
                if (c != 0) begin
                    rd_open(8'(8'h86 + c));
                    rbyte("R12 gpio b0", lo); rbyte("R12 gpio b1", hi); rbyte("R12 gpio b2", 8'h00);
                end
            end
        end
        // R4 soft reset command
        do_rst();
        cmd1(8'h8B, 8'h11); cmd1(8'h90, 8'h44); cmd1(8'h93, 8'h0B); cmd1(8'h81, 8'h07);
        xs(); wbyte(8'h85); wbyte(8'h34); wbyte(8'h12);
        cmd1(8'h83, 8'h55);
        chk("R4 bad key err", {8'h0, err}, 16'h01);
        chk("R4 bad key keeps act", {8'h0, act}, 16'h11);
        cmd1(8'h83, 8'hAA);
        chk("R4 act default", {8'h0, act}, 16'd125);
        chk("R4 ksize default", {8'h0, ksz}, 16'h33);
        chk("R4 clk default", {8'h0, ckc}, 16'h08);
        chk("R4 cfg default", {8'h0, cfg}, 16'h80);
        chk("R4 gpio kept", dir, 16'h1234);
        chk("R4 err kept", {8'h0, err}, 16'h01);
        rd_open(8'h82); rbyte("R4 status fresh", 8'h10);
        // R5 debounce sweep
        for (int v = 0; v < 256; v++) begin
            do_rst(); cmd1(8'h8F, 8'(v));
            chk("R5 dbnc stored", {8'h0, dbnc}, 16'(v));
            chk("R5 dbnc check", {8'h0, err}, (v == 0) ? 16'h01 : 16'h00);
        end
        // R6 keypad size sweep
        for (int v = 0; v < 256; v++) begin
            do_rst(); cmd1(8'h90, 8'(v));
            chk("R6 ksize stored", {8'h0, ksz}, 16'(v));
            chk("R6 ksize check", {8'h0, err}, ksz_bad_f(8'(v)) ? 16'h01 : 16'h00);
            rd_open(8'h91); rbyte("R12 ksize read", 8'(v));
        end
        // R7 clock sweep
        for (int v = 0; v < 256; v++) begin
            do_rst(); cmd1(8'h93, 8'(v));
            chk("R7 clk stored", {8'h0, ckc}, 16'(v));
            chk("R7 clk check", {8'h0, err},
                (v % 4 == 1 || v % 4 == 2) ? 16'h01 : 16'h00);
            rd_open(8'h94); rbyte("R12 clk read", 8'((v & 8'hFC) | 2));
        end
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule